// File: doc/BRIEF.md
# PLL Clock Switch and Bus Divider Controller

This controller decides which clock pulses reach the processor core, the high-speed bus and the peripheral bus. The analog PLL is not part of the block. Both the crystal and the PLL appear as single-cycle enable ticks on one fast design clock. After reset the core runs on crystal ticks. Software programs three registers through a small write/read port: a lock interval, a PLL setting word and a bus divide ratio.

A write to the PLL setting word arms the switch, even when the value written equals what the register already holds. The core enable is then held low while a down-counter loaded from the lock interval consumes crystal ticks. After that the core follows the PLL ticks. The two bus enables are thinned copies of the core enable, at one of four fixed ratios. A ratio change waits for the current peripheral-bus period to finish.

Top module: `clk_switch_div`

## Requirements
- R1: After reset, `pllSelected` is 0. Reads return 0x00FFFFFF at address 0 (lock interval), 0x0005C040 at address 1 (PLL setting) and 0 at address 2 (divide ratio). Address 3 reads 0.
- R2: Until address 1 is written, `coreClkEn` equals `xtalTick` in every cycle. Writes to addresses 0, 2 and 3 do not change this.
- R3: In the cycle after any write to address 1, the lock wait begins. `coreClkEn` stays 0 for as long as the wait lasts.
- R4: The lock wait ends on the N-th crystal tick after the write, where N is the value of lock-interval bits [11:0]. `pllSelected` is 1 from the following cycle. With N = 0 the wait lasts a single cycle.
- R5: The lock-interval register stores 24 bits: [11:0] for the main PLL and [23:12] for the second PLL. Only [11:0] sets the wait. Bits [31:24] read as 0.
- R6: A write to address 0 during a lock wait changes the read-back value but does not shorten, lengthen or restart the wait in progress.
- R7: While `pllSelected` is 1, `coreClkEn` equals `pllTick`. `pllSelected` stays 1 until the next write to address 1.
- R8: Divide field bits [1:0] at address 2 give core:high-speed:peripheral ratios of 1:1:1 (00), 1:1:2 (01), 1:2:2 (10) and 1:2:4 (11). Bit 1 selects high-speed divide-by-2 and bit 0 selects peripheral divide-by-2 relative to the high-speed bus. In each period, the first core pulse carries both bus enables.
- R9: `hbusClkEn` and `pbusClkEn` are asserted only in cycles where `coreClkEn` is asserted.
- R10: A new divide field reads back at once, but it takes effect only after the core pulse that closes the current peripheral-bus period.
- R11: Address 1 keeps only the multiplier [19:12], pre-divider [9:4] and post-scaler [1:0]. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast design clock |
| rstN | input | 1 | Active-low synchronous reset |
| xtalTick | input | 1 | One-cycle pulse per crystal period |
| pllTick | input | 1 | One-cycle pulse per PLL output period |
| regAddr | input | 2 | Register address (0 lock, 1 PLL setting, 2 divide) |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| coreClkEn | output | 1 | Core clock enable |
| hbusClkEn | output | 1 | High-speed bus clock enable |
| pbusClkEn | output | 1 | Peripheral bus clock enable |
| pllSelected | output | 1 | Core is running from the PLL ticks |

## Verification
The bound checker checks these rules in every cycle:
- bus enables never appear without a core enable, and a peripheral enable never appears without a high-speed enable;
- the core is gated throughout a lock wait;
- a setting write always starts a wait;
- the core source is the crystal before the first setting write and the PLL afterwards;
- PLL selection rises only out of a wait.

Only the bench scenarios can show the exact number of crystal ticks a wait consumes, that a mid-wait lock write leaves the wait unchanged, the exact per-pulse bus patterns for each ratio, the delayed ratio switch at a period boundary, and the masked read-back values.

// File: rtl/ckc_pkg.sv
package ckc_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_LOCK = 2'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 2'd1;
  localparam logic [ADDR_W-1:0] A_DIV  = 2'd2;

  typedef enum logic [1:0] {
    ST_XTAL = 2'd0,
    ST_LOCK = 2'd1,
    ST_PLL  = 2'd2
  } srcState_t;

  typedef enum logic [1:0] {
    DIV_111 = 2'd0,
    DIV_112 = 2'd1,
    DIV_122 = 2'd2,
    DIV_124 = 2'd3
  } divSel_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic coreTick;
    logic lockBusy;
    logic onPll;
  } ctlStrobe_t;

endpackage

// File: rtl/ckc_regs.sv
module ckc_regs
  import ckc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LOCK_W   = 12,
  parameter int MUL_LSB  = 12,
  parameter int MUL_W    = 8,
  parameter int PRE_LSB  = 4,
  parameter int PRE_W    = 6,
  parameter int POST_LSB = 0,
  parameter int POST_W   = 2,
  parameter logic [DATA_W-1:0] CFG_RST = 32'h0005_C040
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [LOCK_W-1:0] lockMain,
  output logic              cfgArm,
  output logic [1:0]        divPending
);

  localparam int LOCK_REG_W = 2 * LOCK_W;
  localparam logic [DATA_W-1:0] MUL_MASK  = DATA_W'(((64'd1 << MUL_W) - 1) << MUL_LSB);
  localparam logic [DATA_W-1:0] PRE_MASK  = DATA_W'(((64'd1 << PRE_W) - 1) << PRE_LSB);
  localparam logic [DATA_W-1:0] POST_MASK = DATA_W'(((64'd1 << POST_W) - 1) << POST_LSB);
  localparam logic [DATA_W-1:0] CFG_MASK  = MUL_MASK | PRE_MASK | POST_MASK;

  logic [LOCK_REG_W-1:0] lockReg;
  logic [DATA_W-1:0]     cfgReg;
  logic [1:0]            divReg;

  logic wrLock, wrCfg, wrDiv;

  assign wrLock = regWrEn && (regAddr == A_LOCK);
  assign wrCfg  = regWrEn && (regAddr == A_CFG);
  assign wrDiv  = regWrEn && (regAddr == A_DIV);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockReg <= '1;
      cfgReg  <= CFG_RST & CFG_MASK;
      divReg  <= DIV_111;
    end else begin
      if (wrLock) lockReg <= regWrData[LOCK_REG_W-1:0];
      if (wrCfg)  cfgReg  <= regWrData & CFG_MASK;
      if (wrDiv)  divReg  <= regWrData[1:0];
    end
  end

  always_comb begin
    unique case (regAddr)
      A_LOCK:  regRdData = DATA_W'(lockReg);
      A_CFG:   regRdData = cfgReg;
      A_DIV:   regRdData = DATA_W'(divReg);
      default: regRdData = '0;
    endcase
  end

  assign lockMain   = lockReg[LOCK_W-1:0];
  assign cfgArm     = wrCfg;
  assign divPending = divReg;

endmodule

// File: rtl/ckc_ctrl.sv
module ckc_ctrl
  import ckc_pkg::*;
#(
  parameter int LOCK_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xtalTick,
  input  logic              pllTick,
  input  logic              cfgArm,
  input  logic [LOCK_W-1:0] lockMain,
  output ctlStrobe_t        stb
);

  srcState_t         state;
  logic [LOCK_W-1:0] lockCnt;
  logic              lockEnds;

  // the wait ends on the tick that consumes the last count, or at once when empty
  assign lockEnds = (lockCnt == '0) || (xtalTick && (lockCnt == LOCK_W'(1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_XTAL;
      lockCnt <= '0;
    end else if (cfgArm) begin
      state   <= ST_LOCK;
      lockCnt <= lockMain;
    end else if (state == ST_LOCK) begin
      if (lockEnds) begin
        state <= ST_PLL;
      end else if (xtalTick) begin
        lockCnt <= lockCnt - LOCK_W'(1);
      end
    end
  end

  always_comb begin
    stb.lockBusy = (state == ST_LOCK);
    stb.onPll    = (state == ST_PLL);
    unique case (state)
      ST_XTAL: stb.coreTick = xtalTick;
      ST_PLL:  stb.coreTick = pllTick;
      default: stb.coreTick = 1'b0;
    endcase
  end

endmodule

// File: rtl/ckc_div.sv
module ckc_div
  import ckc_pkg::*;
#(
  parameter int PH_W = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t stb,
  input  logic [1:0] divPending,
  output logic       hbusEn,
  output logic       pbusEn
);

  divSel_t         active;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] hMask, pMask;
  logic            periodEnd;

  always_comb begin
    unique case (active)
      DIV_111: begin hMask = PH_W'(0); pMask = PH_W'(0); end
      DIV_112: begin hMask = PH_W'(0); pMask = PH_W'(1); end
      DIV_122: begin hMask = PH_W'(1); pMask = PH_W'(1); end
      default: begin hMask = PH_W'(1); pMask = PH_W'(3); end
    endcase
  end

  assign periodEnd = ((phase & pMask) == pMask);
  assign hbusEn    = stb.coreTick && ((phase & hMask) == '0);
  assign pbusEn    = stb.coreTick && ((phase & pMask) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= DIV_111;
      phase  <= '0;
    end else if (stb.coreTick) begin
      if (periodEnd) begin
        phase  <= '0;
        active <= divSel_t'(divPending);
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end

endmodule

// File: rtl/clk_switch_div.sv
module clk_switch_div
  import ckc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LOCK_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xtalTick,
  input  logic              pllTick,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              coreClkEn,
  output logic              hbusClkEn,
  output logic              pbusClkEn,
  output logic              pllSelected
);

  logic [LOCK_W-1:0] lockMain;
  logic              cfgArm;
  logic [1:0]        divPending;
  ctlStrobe_t        ctlStb;
  logic              lockBusy;

  ckc_regs #(.DATA_W(DATA_W), .LOCK_W(LOCK_W)) u_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .lockMain(lockMain),
    .cfgArm(cfgArm), .divPending(divPending)
  );

  ckc_ctrl #(.LOCK_W(LOCK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .xtalTick(xtalTick), .pllTick(pllTick),
    .cfgArm(cfgArm), .lockMain(lockMain), .stb(ctlStb)
  );

  ckc_div #(.PH_W(2)) u_div (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .divPending(divPending),
    .hbusEn(hbusClkEn), .pbusEn(pbusClkEn)
  );

  assign coreClkEn   = ctlStb.coreTick;
  assign pllSelected = ctlStb.onPll;
  assign lockBusy    = ctlStb.lockBusy;

endmodule

// File: rtl/clk_switch_div_chk.sv
module clk_switch_div_chk
  import ckc_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       xtalTick,
  input logic       pllTick,
  input logic [1:0] regAddr,
  input logic       regWrEn,
  input logic       coreClkEn,
  input logic       hbusClkEn,
  input logic       pbusClkEn,
  input logic       pllSelected,
  input logic       lockBusy
);

  logic cfgWr;
  assign cfgWr = regWrEn && (regAddr == A_CFG);

  AST_BUS_NEEDS_CORE: assert property (@(posedge clk) disable iff (!rstN)
    (hbusClkEn || pbusClkEn) |-> coreClkEn); // R9
  AST_PBUS_NEEDS_HBUS: assert property (@(posedge clk) disable iff (!rstN)
    pbusClkEn |-> hbusClkEn); // R8
  AST_GATED_IN_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    lockBusy |-> !coreClkEn); // R3
  AST_ARM_STARTS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> lockBusy); // R3
  AST_XTAL_UNTIL_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (!pllSelected && !lockBusy) |-> (coreClkEn == xtalTick)); // R2
  AST_PLL_FROM_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllSelected) |-> $past(lockBusy)); // R4
  AST_PLL_DRIVES_CORE: assert property (@(posedge clk) disable iff (!rstN)
    pllSelected |-> (coreClkEn == pllTick)); // R7
  AST_PLL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (pllSelected && !cfgWr) |=> pllSelected); // R7

endmodule

bind clk_switch_div clk_switch_div_chk u_chk (.*);

// File: tb/sim_clk_switch_div.sv
module sim_clk_switch_div;
  import ckc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int XTAL_DIV   = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xtalTick = 1'b0;
  logic        pllTick = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        coreClkEn, hbusClkEn, pbusClkEn, pllSelected;

  int nChk = 0;
  int nFail = 0;
  int pllMode = 0;   // 0: tick every cycle, 1: alternate cycles
  logic sbOn = 1'b0;
  logic [1:0] expQ[$];
  string tagQ[$];

  clk_switch_div u0 (
    .clk(clk), .rstN(rstN), .xtalTick(xtalTick), .pllTick(pllTick),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .coreClkEn(coreClkEn), .hbusClkEn(hbusClkEn),
    .pbusClkEn(pbusClkEn), .pllSelected(pllSelected)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // tick sources
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk);
      #1;
      ph++;
      xtalTick = (ph % XTAL_DIV == 0);
      pllTick  = (pllMode == 0) ? 1'b1 : ph[0];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // monitor: pops one expected pair per core pulse
  initial begin
    forever begin
      @(negedge clk);
      if (sbOn && coreClkEn) begin
        if (expQ.size() == 0) begin
          chk("R8 unexpected pulse", 32'({hbusClkEn, pbusClkEn}), 32'hx);
        end else begin
          logic [1:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(t, 32'({hbusClkEn, pbusClkEn}), 32'(e));
        end
      end
    end
  end

  task automatic push(input logic h, input logic p, input string t);
    expQ.push_back({h, p});
    tagQ.push_back(t);
  endtask

  task automatic runQueue();
    int m;
    m = expQ.size();
    sbOn = 1'b1;
    repeat (m) @(posedge clk);
    #1 sbOn = 1'b0;
    chk("R8 queue drained", 32'(expQ.size()), 32'd0);
    expQ.delete();
    tagQ.delete();
  endtask

  // R8/R10: switch from 1:1:1 to sel and check several periods
  task automatic runRatio(input logic [1:0] sel, input int periods);
    int plen;
    plen = (sel == 2'b00) ? 1 : (sel == 2'b11) ? 4 : 2;
    regWrite(A_DIV, 32'(sel));
    push(1'b1, 1'b1, "R10 old ratio pulse");
    for (int k = 0; k < periods; k++) begin
      for (int ph = 0; ph < plen; ph++) begin
        push(sel[1] ? (ph % 2 == 0) : 1'b1, ph == 0, "R8 ratio pattern");
      end
    end
    runQueue();
  endtask

  task automatic lockWait(input int expTicks, input string req, input int midWrAt, input logic [31:0] midWrData);
    int ticks;
    int cyc;
    ticks = 0;
    cyc = 0;
    while (1) begin
      @(negedge clk);
      regWrEn = 1'b0;
      if (pllSelected) break;
      if (coreClkEn) chk("R3 core gated in wait", 32'(coreClkEn), 32'd0);
      if (xtalTick) ticks++;
      if (cyc == midWrAt) begin
        regAddr = A_LOCK; regWrData = midWrData; regWrEn = 1'b1;
      end
      cyc++;
      if (cyc > 100000) break;
    end
    chk(req, 32'(ticks), 32'(expTicks));
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    regRead(A_LOCK, rd); chk("R1 lock reset", rd, 32'h00FF_FFFF);
    regRead(A_CFG, rd);  chk("R1 cfg reset", rd, 32'h0005_C040);
    regRead(A_DIV, rd);  chk("R1 div reset", rd, 32'h0);
    regRead(2'd3, rd);   chk("R1 unused addr", rd, 32'h0);
    chk("R1 pllSelected", 32'(pllSelected), 32'd0);

    // R2 core follows crystal, other writes keep it there
    regWrite(A_LOCK, 32'hFFAB_C005);
    regWrite(A_DIV, 32'h1);
    regWrite(2'd3, 32'hFFFF_FFFF);
    begin
      int bad = 0;
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        if (coreClkEn !== xtalTick || pllSelected !== 1'b0) bad++;
      end
      chk("R2 xtal source before arm", 32'(bad), 32'd0);
    end
    regRead(A_LOCK, rd); chk("R5 lock fields", rd, 32'h00AB_C005);
    regRead(A_DIV, rd);  chk("R10 div readback", rd, 32'h1);
    regWrite(A_DIV, 32'h0);

    // R3/R4 arm with the unchanged reset value, wait of 5 ticks
    regWrite(A_CFG, 32'h0005_C040);
    lockWait(5, "R4 lock tick count", -1, 32'h0);
    chk("R4 pllSelected after wait", 32'(pllSelected), 32'd1);
    regRead(A_CFG, rd); chk("R11 cfg same value", rd, 32'h0005_C040);

    // R7 core follows PLL ticks
    pllMode = 1;
    begin
      int bad = 0;
      repeat (2) @(posedge clk);
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (coreClkEn !== pllTick) bad++;
      end
      chk("R7 core follows pll", 32'(bad), 32'd0);
    end
    pllMode = 0;
    repeat (8) @(posedge clk);

    // R8 ratios, each starting from 1:1:1
    runRatio(2'b01, 3);
    regWrite(A_DIV, 32'h0);
    repeat (8) @(posedge clk);
    runRatio(2'b10, 3);
    regWrite(A_DIV, 32'h0);
    repeat (8) @(posedge clk);
    runRatio(2'b11, 2);

    // R10 write during period phase 0: old 1:2:4 period finishes first
    regWrite(A_DIV, 32'h0);
    push(1'b0, 1'b0, "R10 old period ph1");
    push(1'b1, 1'b0, "R10 old period ph2");
    push(1'b0, 1'b0, "R10 old period ph3");
    push(1'b1, 1'b1, "R10 new ratio");
    push(1'b1, 1'b1, "R10 new ratio");
    push(1'b1, 1'b1, "R10 new ratio");
    runQueue();

    // R6/R11 re-arm with all ones, change lock value mid-wait
    regWrite(A_LOCK, 32'd20);
    regWrite(A_CFG, 32'hFFFF_FFFF);
    lockWait(20, "R6 wait unchanged by lock write", 8, 32'd2);
    regRead(A_LOCK, rd); chk("R6 lock readback", rd, 32'd2);
    regRead(A_CFG, rd);  chk("R11 cfg masked", rd, 32'h000F_F3F3);

    // R4 zero interval
    regWrite(A_LOCK, 32'd0);
    regWrite(A_CFG, 32'h0001_2030);
    chk("R3 wait started", 32'(pllSelected), 32'd0);
    @(posedge clk); #1;
    chk("R4 zero wait done", 32'(pllSelected), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule